// File: doc/BRIEF.md
# Normalization Detect and Rounding Unit

This unit works on fixed-point accumulator values and has two functions. The first reports how far the value would have to be shifted to be normalized. Normalized means the sign bit sits at the top of the 32-bit word and the bit just below it differs from the sign. The unit finds the highest bit that differs from the sign bit. The distance from that bit to the normalized position is the count. The unit reports this count and does not perform the shift. The second function rounds the value to its upper word by adding half of one upper-word step and then clearing the 16-bit fraction field.

Each function works in one of two formats. In the guarded format all 40 bits are significant: an 8-bit guard extension sits above a 32-bit word. In the unguarded format only the low 32 bits are used, and the guard bits of the operand are ignored. A normalize count is placed in the integer field (bits 39:16) as a sign-extended integer. A positive count asks for a left shift. A negative count means the guard bits hold significant data and the value must move right. Both functions return N, Z and V flags in the same way as an arithmetic operation. The unit accepts one operation per cycle and returns its result one cycle later.

Top module: `nrd_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock, and `out_result` and the flags belong to the operation accepted on that previous cycle. While `rst_n` is low, `out_valid`, `out_result` and all flags read 0.
- R2: The normalize count uses guarded format when `in_guard_en`=1. Let p be the highest index in 38..0 whose bit differs from bit 39. The count is 30-p, which ranges from -8 to 30.
- R3: The normalize count uses unguarded format when `in_guard_en`=0. Let p be the highest index in 30..0 whose bit differs from bit 31. The count is 30-p, which is never negative. Bits 39:32 of the operand have no effect.
- R4: For normalize, an operand with no bit that differs from the sign bit returns a count of 31. In guarded format this means all 40 bits are 0 or all are 1. In unguarded format it means all 32 low bits are 0 or all are 1.
- R5: Every result has bits 15:0 at zero. For normalize, bits 39:16 hold the count sign-extended to 24 bits.
- R6: For normalize, N=1 exactly when the count is negative and Z=1 exactly when the count is 0. V is always 0.
- R7: Guarded rounding returns (operand + 0x8000) modulo 2^40 with bits 15:0 cleared.
- R8: Unguarded rounding returns (operand[31:0] + 0x8000) modulo 2^32 with bits 15:0 cleared, sign-extended from bit 31 to 40 bits. Bits 39:32 of the operand have no effect.
- R9: Rounding sets V when a non-negative operand in the selected format gives a negative rounded value. The sign is bit 39 in guarded format and bit 31 in unguarded format. With `in_sat_en`=0 the wrapped value of R7 or R8 is returned.
- R10: With `in_sat_en`=1, an overflowing rounding returns the largest positive rounded value: 0x7F_FFFF_0000 in guarded format and 0x00_7FFF_0000 in unguarded format. V is still set.
- R11: For rounding, N equals bit 39 of the result and Z=1 exactly when the whole 40-bit result is 0.
- R12: `in_op`=0 selects normalize detection and `in_op`=1 selects rounding. `in_sat_en` has no effect on normalize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| in_op | input | 1 | 0 = normalize detect, 1 = round |
| in_guard_en | input | 1 | 1 = 40-bit guarded format, 0 = 32-bit unguarded format |
| in_sat_en | input | 1 | Clamp a rounding overflow to the largest positive value |
| in_operand | input | 40 | Accumulator value |
| out_valid | output | 1 | Result valid |
| out_result | output | 40 | Count in the integer field, or the rounded value |
| out_flag_n | output | 1 | Negative flag |
| out_flag_z | output | 1 | Zero flag |
| out_flag_v | output | 1 | Overflow flag |

## Verification
The unit has only a single result register, so a fault in the MSB search or in the carry path shows up at the ports in the result of the very next cycle. A sign-extension fault in unguarded mode shows up as a changed count or a changed upper byte only when the operand's guard bits disagree with bit 31. For that reason the bench fills those bits with junk. A wrong overflow term shows only at the rounding boundary near the positive maximum, which the directed vectors hit in both formats and both saturation settings.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

  typedef enum logic {
    NRD_OP_NORM  = 1'b0,
    NRD_OP_ROUND = 1'b1
  } nrd_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
  } nrd_flags_t;

endpackage

// File: rtl/nrd_operand_fmt.sv
module nrd_operand_fmt #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32
) (
  input  logic             guard_en,
  input  logic [ACC_W-1:0] operand,
  output logic [ACC_W-1:0] value_ext,
  output logic             fmt_sign
);
  localparam int GUARD_W = ACC_W - WORD_W;

  // Unguarded data is re-extended from the word sign so that the
  // downstream logic sees a single 40-bit view of either format.
  function automatic logic [ACC_W-1:0] word_sext(input logic [ACC_W-1:0] v);
    logic [ACC_W-1:0] r;
    r = v;
    for (int i = WORD_W; i < ACC_W; i++) r[i] = v[WORD_W-1];
    return r;
  endfunction

  generate
    if (GUARD_W > 0) begin : g_guarded
      assign value_ext = guard_en ? operand : word_sext(operand);
      assign fmt_sign  = guard_en ? operand[ACC_W-1] : operand[WORD_W-1];
    end else begin : g_plain
      logic unused_guard;
      assign unused_guard = guard_en;
      assign value_ext    = operand;
      assign fmt_sign     = operand[ACC_W-1];
    end
  endgenerate

endmodule

// File: rtl/nrd_msb_detect.sv
module nrd_msb_detect #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    guard_en,
  input  logic [ACC_W-1:0]        value_ext,
  output logic signed [CNT_W-1:0] shift_cnt,
  output logic                    all_sign
);
  localparam int NORM_POS = WORD_W - 2;   // bit just below the word sign
  localparam int MAX_LEFT = WORD_W - 1;   // count for a value with no significant bit
  localparam int MIN_CNT  = -(ACC_W - WORD_W);

  // Highest bit index below the sign that differs from it; -1 when none.
  function automatic int top_diff(input logic [ACC_W-1:0] v);
    int pos;
    pos = -1;
    for (int i = 0; i < ACC_W - 1; i++) begin
      if (v[i] != v[ACC_W-1]) pos = i;
    end
    return pos;
  endfunction

  int diff_pos;

  always_comb begin
    diff_pos = top_diff(value_ext);
    all_sign = (diff_pos < 0);
    if (all_sign) shift_cnt = CNT_W'(MAX_LEFT);
    else          shift_cnt = CNT_W'(NORM_POS - diff_pos);
  end

  // R2: the count never leaves the range a 40-bit value can produce
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(shift_cnt) >= MIN_CNT) && (int'(shift_cnt) <= MAX_LEFT));

  // R3: with the guard bits out of use a right shift is never requested
  a_r3_unguarded_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_en |-> !shift_cnt[CNT_W-1]);

endmodule

// File: rtl/nrd_rounder.sv
module nrd_rounder #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             guard_en,
  input  logic             sat_en,
  input  logic             fmt_sign,
  input  logic [ACC_W-1:0] value_ext,
  output logic [ACC_W-1:0] rnd_value,
  output logic             rnd_ovf
);
  localparam logic [ACC_W-1:0] HALF_STEP = ACC_W'(1) << (FRAC_W - 1);

  function automatic logic [ACC_W-1:0] clear_frac(input logic [ACC_W-1:0] v);
    logic [ACC_W-1:0] r;
    r = v;
    for (int i = 0; i < FRAC_W; i++) r[i] = 1'b0;
    return r;
  endfunction

  function automatic logic [ACC_W-1:0] word_sext(input logic [ACC_W-1:0] v);
    logic [ACC_W-1:0] r;
    r = v;
    for (int i = WORD_W; i < ACC_W; i++) r[i] = v[WORD_W-1];
    return r;
  endfunction

  // Largest positive value whose fraction field is empty, per format.
  function automatic logic [ACC_W-1:0] pos_limit(input logic guarded);
    logic [ACC_W-1:0] r;
    int top;
    top = guarded ? ACC_W - 1 : WORD_W - 1;
    r   = '0;
    for (int i = FRAC_W; i < ACC_W; i++) if (i < top) r[i] = 1'b1;
    return r;
  endfunction

  logic [ACC_W-1:0] raw_sum;
  logic [ACC_W-1:0] wrapped;
  logic             sum_sign;

  always_comb begin
    raw_sum  = value_ext + HALF_STEP;
    sum_sign = guard_en ? raw_sum[ACC_W-1] : raw_sum[WORD_W-1];
    rnd_ovf  = !fmt_sign && sum_sign;
    wrapped  = guard_en ? raw_sum : word_sext(raw_sum);
    if (rnd_ovf && sat_en) rnd_value = pos_limit(guard_en);
    else                   rnd_value = clear_frac(wrapped);
  end

  // R9: adding a positive half step can only overflow from the positive side
  a_r9_ovf_from_positive: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_ovf |-> !fmt_sign);

  // R10: a saturated result stays positive
  a_r10_sat_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_ovf && sat_en) |-> !rnd_value[ACC_W-1]);

endmodule

// File: rtl/nrd_unit.sv
module nrd_unit #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_op,
  input  logic             in_guard_en,
  input  logic             in_sat_en,
  input  logic [ACC_W-1:0] in_operand,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_result,
  output logic             out_flag_n,
  output logic             out_flag_z,
  output logic             out_flag_v
);
  import nrd_pkg::*;

  localparam int CNT_W = $clog2(ACC_W) + 1;
  localparam int EXT_W = ACC_W - CNT_W - FRAC_W;

  nrd_op_e             op_sel;
  logic [ACC_W-1:0]    value_ext;
  logic                fmt_sign;
  logic signed [CNT_W-1:0] shift_cnt;
  logic                all_sign;
  logic [ACC_W-1:0]    rnd_value;
  logic                rnd_ovf;

  logic [ACC_W-1:0]    nxt_result;
  nrd_flags_t          nxt_flags;
  nrd_flags_t          flags_q;

  assign op_sel = nrd_op_e'(in_op);

  nrd_operand_fmt #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_fmt (
    .guard_en  (in_guard_en),
    .operand   (in_operand),
    .value_ext (value_ext),
    .fmt_sign  (fmt_sign)
  );

  nrd_msb_detect #(.ACC_W(ACC_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_msb (
    .clk       (clk),
    .rst_n     (rst_n),
    .guard_en  (in_guard_en),
    .value_ext (value_ext),
    .shift_cnt (shift_cnt),
    .all_sign  (all_sign)
  );

  nrd_rounder #(.ACC_W(ACC_W), .WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_rnd (
    .clk       (clk),
    .rst_n     (rst_n),
    .guard_en  (in_guard_en),
    .sat_en    (in_sat_en),
    .fmt_sign  (fmt_sign),
    .value_ext (value_ext),
    .rnd_value (rnd_value),
    .rnd_ovf   (rnd_ovf)
  );

  // Count placed in the integer field, sign-extended, fraction cleared.
  function automatic logic [ACC_W-1:0] place_count(input logic signed [CNT_W-1:0] c);
    return {{EXT_W{c[CNT_W-1]}}, c, {FRAC_W{1'b0}}};
  endfunction

  always_comb begin
    if (op_sel == NRD_OP_NORM) begin
      nxt_result  = place_count(shift_cnt);
      nxt_flags.n = shift_cnt[CNT_W-1];
      nxt_flags.z = (shift_cnt == '0);
      nxt_flags.v = 1'b0;
    end else begin
      nxt_result  = rnd_value;
      nxt_flags.n = rnd_value[ACC_W-1];
      nxt_flags.z = (rnd_value == '0);
      nxt_flags.v = rnd_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      flags_q    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nxt_result;
        flags_q    <= nxt_flags;
      end
    end
  end

  assign out_flag_n = flags_q.n;
  assign out_flag_z = flags_q.z;
  assign out_flag_v = flags_q.v;

  // R1: one-cycle latency on the valid strobe
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R5: the fraction field of any result is empty
  a_r5_frac_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[FRAC_W-1:0] == '0));

  // R6: a normalize count never raises overflow
  a_r6_norm_no_v: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == NRD_OP_NORM) |=> !out_flag_v);

  // R4: a value without any significant bit asks for a positive count
  a_r4_flat_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == NRD_OP_NORM && all_sign) |=> (!out_flag_n && !out_flag_z));

  // R11: flags agree with the registered result
  a_r11_n_tracks_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flag_n == out_result[ACC_W-1]));
  a_r11_z_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag_z) |-> (out_result == '0));

  // R10: saturated rounding of a non-negative value stays non-negative
  a_r10_no_wrap_when_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == NRD_OP_ROUND && in_sat_en && !fmt_sign) |=> !out_flag_n);

endmodule

// File: tb/nrd_unit_tb.sv
`timescale 1ns/1ps
module nrd_unit_tb;

  typedef struct packed {
    logic [39:0] res;
    logic        n;
    logic        z;
    logic        v;
    logic        is_round;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_op = 1'b0;
  logic        in_guard_en = 1'b0;
  logic        in_sat_en = 1'b0;
  logic [39:0] in_operand = '0;
  logic        out_valid;
  logic [39:0] out_result;
  logic        out_flag_n, out_flag_z, out_flag_v;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 0;
  exp_t sb_q[$];
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  nrd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_guard_en(in_guard_en), .in_sat_en(in_sat_en), .in_operand(in_operand),
    .out_valid(out_valid), .out_result(out_result),
    .out_flag_n(out_flag_n), .out_flag_z(out_flag_z), .out_flag_v(out_flag_v)
  );

  // Normalize model: count leading copies of the sign below the sign bit.
  function automatic exp_t model_norm(input logic [39:0] d, input logic g);
    exp_t e;
    int run, top, cnt;
    logic s;
    top = g ? 39 : 31;
    s   = d[top];
    run = 0;
    for (int i = top - 1; i >= 0; i--) begin
      if (d[i] != s) break;
      run++;
    end
    if (run == top) cnt = 31;
    else            cnt = g ? run - 8 : run;
    e.res      = 40'(longint'(cnt) * 65536);
    e.n        = (cnt < 0);
    e.z        = (cnt == 0);
    e.v        = 1'b0;
    e.is_round = 1'b0;
    return e;
  endfunction

  // Rounding model in signed integer arithmetic.
  function automatic exp_t model_round(input logic [39:0] d, input logic g, input logic s);
    exp_t e;
    longint val, sum, lim, span;
    if (g) begin
      val = longint'({{24{d[39]}}, d});
      lim = 64'h7F_FFFF_FFFF;
      span = 64'h100_0000_0000;
    end else begin
      val = longint'({{32{d[31]}}, d[31:0]});
      lim = 64'h7FFF_FFFF;
      span = 64'h1_0000_0000;
    end
    sum = val + 32768;
    e.v = (sum > lim);
    if (e.v && s) sum = lim;
    else if (e.v) sum = sum - span;
    sum = sum - (sum % 65536 + 65536) % 65536;
    e.res      = 40'(sum);
    e.n        = e.res[39];
    e.z        = (e.res == '0);
    e.is_round = 1'b1;
    return e;
  endfunction

  task automatic apply(input logic op, input logic g, input logic s, input logic [39:0] d);
    @(negedge clk);
    in_valid    = 1'b1;
    in_op       = op;
    in_guard_en = g;
    in_sat_en   = s;
    in_operand  = d;
    sb_q.push_back(op ? model_round(d, g, s) : model_norm(d, g));
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_operand = 40'hDE_AD00_BEEF;
    end
  endtask

  function automatic logic [63:0] next_rng(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  // Monitor: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 are all judged here.
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      n_checks++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R1: out_valid with no pending operation (got %h, expected none)", out_result);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if ({out_result, out_flag_n, out_flag_z, out_flag_v} !== {e.res, e.n, e.z, e.v}) begin
          n_fail++;
          $display("FAIL %s: result/NZV got %h/%b%b%b expected %h/%b%b%b",
                   e.is_round ? "R7-round R8 R9 R10 R11" : "R2-norm R3 R4 R5 R6",
                   out_result, out_flag_n, out_flag_z, out_flag_v,
                   e.res, e.n, e.z, e.v);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end (got hang, expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    n_checks++;
    if ({out_valid, out_result, out_flag_n, out_flag_z, out_flag_v} !== '0) begin
      n_fail++;
      $display("FAIL R1: reset outputs got %b/%h expected 0/0", out_valid, out_result);
    end
    rst_n = 1'b1;
    idle(2);

    // R2 guarded normalize boundaries
    apply(1'b0, 1'b1, 1'b0, 40'h7F_FFFF_FFFF);   // -8
    apply(1'b0, 1'b1, 1'b0, 40'h00_4000_0000);   // 0
    apply(1'b0, 1'b1, 1'b0, 40'h00_0000_0001);   // 30
    apply(1'b0, 1'b1, 1'b0, 40'hFF_8000_0000);   // 0
    apply(1'b0, 1'b1, 1'b0, 40'h80_0000_0000);   // -8
    apply(1'b0, 1'b1, 1'b0, 40'h01_0000_0000);   // -2
    // R4 flat values in both formats
    apply(1'b0, 1'b1, 1'b0, 40'h00_0000_0000);
    apply(1'b0, 1'b1, 1'b0, 40'hFF_FFFF_FFFF);
    apply(1'b0, 1'b0, 1'b0, 40'h5A_0000_0000);
    apply(1'b0, 1'b0, 1'b0, 40'h13_FFFF_FFFF);
    // R3 unguarded with junk guard bits; R12 sat ignored on normalize
    apply(1'b0, 1'b0, 1'b1, 40'hAB_0000_0001);   // 30
    apply(1'b0, 1'b0, 1'b0, 40'h7F_4000_0000);   // 0
    apply(1'b0, 1'b0, 1'b1, 40'h00_FFFF_0000);   // 15
    idle(1);

    // R7 guarded rounding
    apply(1'b1, 1'b1, 1'b0, 40'h00_1234_7FFF);
    apply(1'b1, 1'b1, 1'b0, 40'h00_1234_8000);
    apply(1'b1, 1'b1, 1'b0, 40'hFF_FFFF_8000);   // rounds to zero
    apply(1'b1, 1'b1, 1'b0, 40'h80_0000_0000);
    // R8 unguarded rounding with junk guard bits
    apply(1'b1, 1'b0, 1'b0, 40'hC3_1234_8000);
    apply(1'b1, 1'b0, 1'b0, 40'h11_FFFF_7FFF);
    // R9 / R10 overflow at the positive edge, both formats, both sat modes
    apply(1'b1, 1'b1, 1'b0, 40'h7F_FFFF_8000);
    apply(1'b1, 1'b1, 1'b1, 40'h7F_FFFF_8000);
    apply(1'b1, 1'b0, 1'b0, 40'h00_7FFF_8000);
    apply(1'b1, 1'b0, 1'b1, 40'h00_7FFF_8000);
    apply(1'b1, 1'b0, 1'b1, 40'hEE_7FFF_7FFF);   // no overflow
    apply(1'b1, 1'b1, 1'b1, 40'h7F_FFFF_7FFF);   // no overflow
    idle(2);

    // Mixed streaming traffic
    for (int k = 0; k < 400; k++) begin
      logic [39:0] d;
      rng = next_rng(rng);
      d = rng[39:0];
      if (rng[47]) d = 40'($signed(d) >>> rng[53:48] % 40);
      apply(rng[60], rng[61], rng[62], d);
      if (rng[63] && rng[59]) idle(1);
    end
    idle(3);

    // R1: strobe drops with no input
    n_checks++;
    if (out_valid !== 1'b0 || sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: after drain valid=%b pending=%0d expected 0/0", out_valid, sb_q.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule